// File: doc/BRIEF.md
# Wormhole Connection Arbiter and Symbol Crossbar

This block is the connection-control core of an eleven-port packet router that uses wormhole switching. Each input port presents a request, the index of the output it wants and a priority flag. When the wanted output is free, the block connects the input to it. The packet's symbols, 8 data bits plus a control/data flag, then pass combinationally through the crossbar. Nothing is buffered. The connection stays in place until the end-of-packet symbol is accepted from the connected input, and that releases the output.

An input whose output is taken is stalled: its symbols are not accepted until it wins the output. Each output has its own arbiter. High-priority waiters are served first. Within a priority class the winner is chosen in a rotating order that starts just after the last input granted that output. When an output frees at an end-of-packet and inputs are waiting, the next owner takes over on the same clock edge, so the output loses no cycle. All eleven ports are switched identically, whatever kind of link sits behind them.

Top module: `wsc_switch_core`

## Requirements
- R1: A synchronous active-low reset clears every connection. After reset, `out_grant`, `out_valid`, `in_accept` and `in_conn` are all zero, and every rotation pointer is at input 0.
- R2: A request that finds its output with no owner is granted at the next rising edge. From the following cycle, `out_grant[o]` has bit i set, `in_conn[i]` is 1 and `in_map[i]` equals o.
- R3: Granting never depends on the state of other outputs. An input that requests an output without an owner is always granted, no matter how many other connections are active.
- R4: While input i owns output o, `out_valid[o]` equals `in_valid[i]`, `out_sym[o]` equals `in_sym[i]`, and `in_accept[i]` equals `in_valid[i]` in the same cycle.
- R5: An input with no connection never has `in_accept` set, whatever its `in_valid` is, and it stalls. An output with no owner has `out_valid` at 0.
- R6: A connection is held unchanged until the connected input has a symbol accepted whose flag bit 8 is 1 and whose low byte equals `EOP_CODE` (default 8'h00). At the following edge, the connection ends and the output is freed. Data symbols with byte 8'h00 and other control symbols do not end it.
- R7: If other inputs are waiting when an output frees at an end-of-packet, one of them owns the output from the very next cycle. The releasing input cannot win on that edge.
- R8: When an output is granted, a waiting request with `in_prio` = 1 wins over every request with `in_prio` = 0.
- R9: Within the winning priority class, the winner is the first requester found from the output's pointer upward, with wrap-around after input 10. The pointer then moves to the winner plus one, modulo 11.
- R10: An input owns at most one output. While it is connected, its `in_req` and `in_dest` have no effect.
- R11: A request whose `in_dest` is 11 or higher is ignored. The input is never granted and is never accepted.
- R12: Each output carries one packet at a time: header, data and end-of-packet arrive complete and in order, and symbols from different inputs are never interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | 11 | Per input: request a connection |
| in_prio | input | 11 | Per input: request is high priority |
| in_dest | input | 11×4 | Per input: wanted output index |
| in_valid | input | 11 | Per input: a symbol is offered |
| in_sym | input | 11×9 | Per input: symbol, bit 8 = control flag |
| in_accept | output | 11 | Per input: symbol taken this cycle |
| in_conn | output | 11 | Per input: input currently owns an output |
| in_map | output | 11×4 | Per input: index of the output it owns |
| out_grant | output | 11×11 | Per output: one-hot owning input |
| out_valid | output | 11 | Per output: a symbol is delivered |
| out_sym | output | 11×9 | Per output: delivered symbol |

## Verification
The release of an output and the grant of that same output to a waiting input fall on the same edge, and the arbitration has to exclude the input that is just leaving. The bench queues one high-priority input and several normal-priority inputs behind a long packet, then lets the owner finish. On the cycle after each end-of-packet, it checks that `out_grant` names the input expected from priority and rotation, with no idle cycle in between. Random traffic repeats the collision on many outputs at once, while a bench model of the request rules checks every cycle and a per-output scoreboard confirms that packets stay whole.

// File: rtl/wsc_pkg.sv
// Package: shared symbol layout for the wormhole switch core.
// Assumes 9-bit symbols: bit 8 is the control flag, bits 7:0 the byte.
package wsc_pkg;

    localparam int SYM_W = 9;

    typedef logic [SYM_W-1:0] wsc_sym_t;

    // True when a symbol is the control symbol that closes a packet.
    function automatic logic wsc_is_end(input wsc_sym_t s, input logic [7:0] code);
        return s[SYM_W-1] && (s[7:0] == code);
    endfunction

endpackage

// File: rtl/wsc_rr_arbiter.sv
// Module: per-output arbiter. Among the requests, high-priority ones form
// the pool if any exist; the winner is the first pool member found from
// the rotation pointer upward with wrap-around. The pointer moves past
// the winner only when the owning logic takes the grant (take = 1).
// Assumes req holds only inputs that are eligible for this output.
module wsc_rr_arbiter #(
    parameter int NP = 11,
    localparam int IW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    input  logic [NP-1:0] hi,
    input  logic          take,
    output logic          win_v,
    output logic [IW-1:0] win_idx
);

    logic [IW-1:0] ptr;
    logic [NP-1:0] hi_req;
    logic [NP-1:0] pool;

    // Restrict the pool to high-priority requests when any are present.
    always_comb begin
        hi_req = req & hi;
        pool   = (|hi_req) ? hi_req : req;
    end

    // Rotating search from the pointer for the first pool member.
    always_comb begin
        win_v   = 1'b0;
        win_idx = '0;
        for (int k = 0; k < NP; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= NP) idx = idx - NP;
            if (!win_v && pool[idx]) begin
                win_v   = 1'b1;
                win_idx = IW'(idx);
            end
        end
    end

    // Advance the pointer to one past the winner when the grant is used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (take && win_v) begin
            ptr <= (win_idx == IW'(NP-1)) ? '0 : win_idx + 1'b1;
        end
    end

    // R9: a winner is always one of the requests.
    assert_win_is_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        win_v |-> req[win_idx]);

    // R8: a high-priority request present means a high-priority winner.
    assert_prio_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_v && |(req & hi)) |-> hi[win_idx]);

endmodule

// File: rtl/wsc_crossbar.sv
// Module: AND-OR symbol crossbar. Each output forwards the symbol and the
// valid of the input selected by its one-hot select row.
// Assumes each select row is one-hot or zero.
module wsc_crossbar #(
    parameter int NP = 11,
    parameter int SW = 9
) (
    input  logic [NP-1:0][NP-1:0] sel,
    input  logic [NP-1:0][SW-1:0] in_sym,
    input  logic [NP-1:0]         in_valid,
    output logic [NP-1:0][SW-1:0] out_sym,
    output logic [NP-1:0]         out_valid
);

    for (genvar o = 0; o < NP; o++) begin : g_out
        // Merge the selected input onto this output.
        always_comb begin
            out_sym[o]   = '0;
            out_valid[o] = 1'b0;
            for (int i = 0; i < NP; i++) begin
                out_sym[o]   = out_sym[o] | (in_sym[i] & {SW{sel[o][i]}});
                out_valid[o] = out_valid[o] | (in_valid[i] & sel[o][i]);
            end
        end
    end

endmodule

// File: rtl/wsc_switch_core.sv
// Module: top of the wormhole connection core. It holds one owner register
// per output and derives from it the per-input connection map. The
// register is released when the owner's end symbol is accepted, and the
// next owner is loaded from the output's arbiter on that same edge.
// Assumes the header lookup has already produced in_dest and that in_req,
// in_dest and in_prio stay stable until the input is connected.
module wsc_switch_core #(
    parameter int         NP       = 11,
    parameter logic [7:0] EOP_CODE = 8'h00,
    localparam int        DW       = $clog2(NP),
    localparam int        SW       = wsc_pkg::SYM_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NP-1:0]         in_req,
    input  logic [NP-1:0]         in_prio,
    input  logic [NP-1:0][DW-1:0] in_dest,
    input  logic [NP-1:0]         in_valid,
    input  logic [NP-1:0][SW-1:0] in_sym,
    output logic [NP-1:0]         in_accept,
    output logic [NP-1:0]         in_conn,
    output logic [NP-1:0][DW-1:0] in_map,
    output logic [NP-1:0][NP-1:0] out_grant,
    output logic [NP-1:0]         out_valid,
    output logic [NP-1:0][SW-1:0] out_sym
);

    logic [NP-1:0]         own_v;
    logic [NP-1:0][DW-1:0] own_idx;
    logic [NP-1:0][NP-1:0] own_oh;   // [output][input]
    logic [NP-1:0][NP-1:0] own_col;  // [input][output]
    logic [NP-1:0]         end_seen;
    logic [NP-1:0]         rel_out;
    logic [NP-1:0]         free_out;
    logic [NP-1:0][NP-1:0] req_mat;  // [output][input]
    logic [NP-1:0]         arb_v;
    logic [NP-1:0][DW-1:0] arb_idx;

    // Decode owner registers into one-hot rows and their transpose.
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                own_oh[o][i]  = own_v[o] && (own_idx[o] == DW'(i));
                own_col[i][o] = own_oh[o][i];
            end
        end
    end

    // Per-input connection state, map and acceptance.
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            in_conn[i]   = |own_col[i];
            in_map[i]    = '0;
            for (int o = 0; o < NP; o++) begin
                if (own_col[i][o]) in_map[i] = in_map[i] | DW'(o);
            end
            in_accept[i] = in_conn[i] && in_valid[i];
            end_seen[i]  = in_accept[i] && wsc_pkg::wsc_is_end(in_sym[i], EOP_CODE);
        end
    end

    // Release and eligibility per output; connected inputs cannot request.
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            rel_out[o]  = |(own_oh[o] & end_seen);
            free_out[o] = !own_v[o] || rel_out[o];
            for (int i = 0; i < NP; i++) begin
                req_mat[o][i] = in_req[i] && !in_conn[i] && (in_dest[i] == DW'(o));
            end
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_arb
        wsc_rr_arbiter #(.NP(NP)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_mat[o]),
            .hi      (in_prio),
            .take    (free_out[o]),
            .win_v   (arb_v[o]),
            .win_idx (arb_idx[o])
        );

        // Owner register: hold while busy, reload from arbiter when free.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                own_v[o]   <= 1'b0;
                own_idx[o] <= '0;
            end else if (free_out[o]) begin
                own_v[o] <= arb_v[o];
                if (arb_v[o]) own_idx[o] <= arb_idx[o];
            end
        end

        // R6: a busy output without an end symbol keeps its owner.
        assert_hold_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (own_v[o] && !rel_out[o]) |=> (own_v[o] && own_idx[o] == $past(own_idx[o])));

        // R7: the releasing input is never the owner after the edge.
        assert_release_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rel_out[o] |=> !(own_v[o] && own_idx[o] == $past(own_idx[o])));

        // R3: an idle output with an eligible request is owned next cycle.
        assert_no_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!own_v[o] && |req_mat[o]) |=> own_v[o]);
    end

    for (genvar i = 0; i < NP; i++) begin : g_in_chk
        // R10: an input owns at most one output at any time.
        assert_single_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(own_col[i]) <= 1);
    end

    assign out_grant = own_oh;

    wsc_crossbar #(.NP(NP), .SW(SW)) u_xbar (
        .sel       (own_oh),
        .in_sym    (in_sym),
        .in_valid  (in_valid),
        .out_sym   (out_sym),
        .out_valid (out_valid)
    );

endmodule

// File: tb/wsc_switch_core_tb.sv
// Bench: per-input packet drivers, a cycle model of the connection rules,
// and a per-output packet scoreboard.
module wsc_switch_core_tb;

    localparam int NP = 11;
    localparam int DW = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NP-1:0]         in_req = '0;
    logic [NP-1:0]         in_prio = '0;
    logic [NP-1:0][DW-1:0] in_dest = '0;
    logic [NP-1:0]         in_valid = '0;
    logic [NP-1:0][8:0]    in_sym = '0;
    logic [NP-1:0]         in_accept;
    logic [NP-1:0]         in_conn;
    logic [NP-1:0][DW-1:0] in_map;
    logic [NP-1:0][NP-1:0] out_grant;
    logic [NP-1:0]         out_valid;
    logic [NP-1:0][8:0]    out_sym;

    wsc_switch_core u_dut (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_prio(in_prio),
        .in_dest(in_dest), .in_valid(in_valid), .in_sym(in_sym),
        .in_accept(in_accept), .in_conn(in_conn), .in_map(in_map),
        .out_grant(out_grant), .out_valid(out_valid), .out_sym(out_sym)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit rnd_mode = 1'b0;

    // Driver state per input
    int d_act[NP], d_dest[NP], d_prio[NP], d_len[NP], d_pos[NP], d_hold[NP];
    // Model state per output
    int m_v[NP], m_idx[NP], m_ptr[NP];
    bit mconn[NP], macc[NP], meop[NP];
    int mmap[NP];
    int n_v[NP], n_idx[NP], n_ptr[NP];
    // Scoreboard per output
    int o_cnt[NP], o_src[NP];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [8:0] sym_of(input int i, input int pos);
        if (pos == 0)                  return {1'b0, 8'(d_dest[i])};
        if (pos == d_len[i] + 1)       return 9'h100;
        if (pos == 1 && (i % 2) == 1)  return 9'h103;
        return {1'b0, 4'(i), 4'(pos)};
    endfunction

    task automatic start_pkt(input int i, input int dest, input int prio, input int len);
        d_act[i] = 1; d_dest[i] = dest; d_prio[i] = prio; d_len[i] = len;
        d_pos[i] = 0; d_hold[i] = 4;
    endtask

    task automatic drive();
        for (int i = 0; i < NP; i++) begin
            in_prio[i]  = (d_prio[i] != 0);
            in_sym[i]   = sym_of(i, d_pos[i]);
            in_valid[i] = (d_act[i] != 0) && (!rnd_mode || ($urandom % 4) != 0);
            if (d_act[i] != 0 && d_pos[i] == 0) begin
                in_req[i]  = 1'b1;
                in_dest[i] = DW'(d_dest[i]);
            end else begin
                // Connected inputs sometimes raise a stray request (R10).
                in_req[i]  = (d_act[i] != 0) && rnd_mode && ($urandom % 5) == 0;
                in_dest[i] = DW'($urandom % 16);
            end
        end
    endtask

    task automatic model_eval();
        for (int i = 0; i < NP; i++) begin mconn[i] = 0; mmap[i] = 0; end
        for (int o = 0; o < NP; o++)
            if (m_v[o] != 0) begin mconn[m_idx[o]] = 1; mmap[m_idx[o]] = o; end
        for (int i = 0; i < NP; i++) begin
            macc[i] = mconn[i] && in_valid[i];
            meop[i] = macc[i] && (in_sym[i] == 9'h100);
        end
        for (int o = 0; o < NP; o++) begin
            bit rel, fr, anyhi;
            bit cand[NP];
            int win;
            n_v[o] = m_v[o]; n_idx[o] = m_idx[o]; n_ptr[o] = m_ptr[o];
            rel = (m_v[o] != 0) && meop[m_idx[o]];
            fr  = (m_v[o] == 0) || rel;
            if (fr) begin
                anyhi = 0;
                for (int i = 0; i < NP; i++) begin
                    cand[i] = in_req[i] && !mconn[i] && (int'(in_dest[i]) == o);
                    if (cand[i] && in_prio[i]) anyhi = 1;
                end
                win = -1;
                for (int k = 0; k < NP; k++) begin
                    int idx;
                    idx = (m_ptr[o] + k) % NP;
                    if (win < 0 && cand[idx] && (!anyhi || in_prio[idx])) win = idx;
                end
                if (win >= 0) begin
                    n_v[o] = 1; n_idx[o] = win; n_ptr[o] = (win + 1) % NP;
                end else begin
                    n_v[o] = 0;
                end
            end
        end
    endtask

    task automatic compare();
        for (int o = 0; o < NP; o++) begin
            logic [NP-1:0] eg;
            eg = '0;
            if (m_v[o] != 0) eg[m_idx[o]] = 1'b1;
            chk(out_grant[o] == eg, "R2 R8 R9", $sformatf("grant out%0d", o), out_grant[o], eg);
            chk(out_valid[o] == ((m_v[o] != 0) && in_valid[m_idx[o]]), "R4 R5",
                $sformatf("out_valid out%0d", o), out_valid[o], (m_v[o] != 0) && in_valid[m_idx[o]]);
            if (m_v[o] != 0 && in_valid[m_idx[o]])
                chk(out_sym[o] == in_sym[m_idx[o]], "R4", $sformatf("out_sym out%0d", o),
                    out_sym[o], in_sym[m_idx[o]]);
        end
        for (int i = 0; i < NP; i++) begin
            chk(in_accept[i] == macc[i], "R5", $sformatf("accept in%0d", i), in_accept[i], macc[i]);
            chk(in_conn[i] == mconn[i], "R10", $sformatf("conn in%0d", i), in_conn[i], mconn[i]);
            if (mconn[i])
                chk(int'(in_map[i]) == mmap[i], "R10", $sformatf("map in%0d", i), in_map[i], mmap[i]);
        end
        // Output-side packet scoreboard.
        for (int o = 0; o < NP; o++) begin
            if (out_valid[o]) begin
                logic [8:0] es;
                if (o_cnt[o] == 0) begin
                    o_src[o] = 0;
                    for (int i = 0; i < NP; i++) if (out_grant[o][i]) o_src[o] = i;
                end
                chk(out_grant[o][o_src[o]], "R12", $sformatf("interleave out%0d", o),
                    out_grant[o], 1 << o_src[o]);
                es = sym_of(o_src[o], o_cnt[o]);
                chk(out_sym[o] == es, "R12", $sformatf("order out%0d pos%0d", o, o_cnt[o]),
                    out_sym[o], es);
                if (es == 9'h100) o_cnt[o] = 0;
                else o_cnt[o]++;
            end
        end
    endtask

    task automatic advance();
        for (int i = 0; i < NP; i++) begin
            if (d_act[i] != 0) begin
                if (macc[i]) begin
                    if (d_pos[i] == d_len[i] + 1) d_act[i] = 0;
                    else d_pos[i]++;
                end else if (d_dest[i] >= NP) begin
                    d_hold[i]--;
                    if (d_hold[i] <= 0) d_act[i] = 0;
                end
            end
        end
        for (int o = 0; o < NP; o++) begin
            m_v[o] = n_v[o]; m_idx[o] = n_idx[o]; m_ptr[o] = n_ptr[o];
        end
    endtask

    task automatic step();
        @(negedge clk);
        drive();
        #1;
        model_eval();
        compare();
        advance();
    endtask

    task automatic run_until_done(input int i);
        int guard;
        guard = 0;
        while (d_act[i] != 0 && guard < 300) begin step(); guard++; end
    endtask

    task automatic check_owner(input int o, input int exp_i, input string tag);
        @(posedge clk); #2;
        chk(out_grant[o] == NP'(1 << exp_i), tag, $sformatf("handover out%0d", o),
            out_grant[o], 1 << exp_i);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NP; i++) begin
            d_act[i] = 0; d_dest[i] = 0; d_prio[i] = 0; d_len[i] = 1; d_pos[i] = 0; d_hold[i] = 0;
        end
        for (int o = 0; o < NP; o++) begin
            m_v[o] = 0; m_idx[o] = 0; m_ptr[o] = 0; o_cnt[o] = 0; o_src[o] = 0;
        end
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk(out_grant == '0, "R1", "grant after reset", out_grant, 0);
        chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_accept == '0 && in_conn == '0, "R1", "accept/conn after reset",
            {in_accept, in_conn}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: long owner on output 5, then a queue behind it.
        start_pkt(4, 5, 0, 6);
        step(); step();
        start_pkt(1, 5, 0, 2);
        start_pkt(2, 5, 0, 2);
        start_pkt(7, 5, 0, 2);
        start_pkt(3, 5, 1, 2);
        start_pkt(6, 9, 0, 2);
        start_pkt(8, 13, 0, 2);
        step();
        @(posedge clk); #2;
        chk(out_grant[9] == NP'(1 << 6), "R3", "idle output granted beside busy one",
            out_grant[9], 1 << 6);
        begin
            logic [NP-1:0] col8;
            for (int o = 0; o < NP; o++) col8[o] = out_grant[o][8];
            chk(col8 == '0, "R11", "dest 13 never granted", col8, 0);
        end
        chk(in_accept[8] == 1'b0, "R5", "stalled input not accepted", in_accept[8], 0);
        chk(out_grant[5] == NP'(1 << 4), "R6", "owner held while others wait",
            out_grant[5], 1 << 4);
        run_until_done(4);
        check_owner(5, 3, "R8");
        run_until_done(3);
        check_owner(5, 7, "R9");
        run_until_done(7);
        check_owner(5, 1, "R9");
        run_until_done(1);
        check_owner(5, 2, "R7");
        run_until_done(2);
        @(posedge clk); #2;
        chk(out_grant[5] == '0, "R6", "output freed after last packet", out_grant[5], 0);
        repeat (6) step();

        // Random traffic
        rnd_mode = 1'b1;
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < NP; i++) begin
                if (d_act[i] == 0 && ($urandom % 6) == 0) begin
                    int dst;
                    dst = (($urandom % 16) == 0) ? 11 + int'($urandom % 5) : int'($urandom % NP);
                    start_pkt(i, dst, (($urandom % 4) == 0) ? 1 : 0, 1 + int'($urandom % 6));
                end
            end
            step();
        end
        rnd_mode = 1'b0;
        begin
            int guard;
            bit busy;
            guard = 0;
            busy = 1;
            while (busy && guard < 2000) begin
                busy = 0;
                for (int i = 0; i < NP; i++) if (d_act[i] != 0) busy = 1;
                step();
                guard++;
            end
        end
        @(posedge clk); #2;
        chk(out_grant == '0, "R6", "all outputs free after drain", out_grant, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule